// File: doc/BRIEF.md
# SPI Engine Register Front-End

This block is the memory-mapped face of a command-driven SPI engine. Software reaches it through a simple 32-bit read/write strobe bus and fills two queues: one of 16-bit command words and one of outgoing data bytes. The engine drains both through valid/ready streams. Bytes the engine captures come back through a third queue, which software empties or inspects without consuming.

Each queue reports its free room or fill level. An interrupt unit latches four events: the command queue running low, the transmit queue running low, the receive queue filling up, and a sync marker reported by the engine. Each event can be enabled on its own and cleared by writing a one. A soft reset bit holds the engine and flushes all three queues. A version word identifies the block, and the ID of the most recent sync event can be read back.

Top module: `spi_front_regs`

## Requirements
- R1: A read of offset 0x00 returns {8'h00, major 8'h01, minor, patch}, with minor and patch as parameters; a read of any unmapped offset returns 0.
- R2: A read strobe in cycle N gives bus_rvalid high and the read data on bus_rdata in cycle N+1, and in no other cycle.
- R3: A write to 0xE0 pushes bus_wdata[15:0] onto the command queue. The queue is offered in order on cmd_valid/cmd_data, and a word leaves on each cycle with cmd_valid and cmd_ready both high. Offset 0xD0 reads the free room, which is CMD_DEPTH minus the fill level.
- R4: A write to 0xE4 pushes bus_wdata[7:0] onto the transmit queue, which is offered in order on tx_valid/tx_data. Offset 0xD4 reads its free room.
- R5: While rx_ready is high, rx_valid pushes rx_data onto the receive queue; rx_ready is low when that queue is full. Offset 0xD8 reads the fill level. A read of 0xE8 returns the head byte and pops it. A read of 0xEC returns the head byte and leaves the queue unchanged.
- R6: A push to a full queue is dropped and leaves the queued contents unchanged. A pop from an empty receive queue returns 0 and changes nothing.
- R7: Writing 1 to bit 0 of 0x40 raises eng_rst, which holds cmd_valid and tx_valid low. While the bit is set, all queues are cleared and every push is dropped. Writing 0 releases the hold, and the bit reads back at 0x40.
- R8: Pending bits 0, 1 and 2 are set one cycle after their condition rises. Bit 0 is command level <= CMD_AE, bit 1 is transmit level <= TX_AE, and bit 2 is receive level >= RX_AF. Offset 0x84 reads the pending bits.
- R9: A cycle with sync_valid high stores sync_id, which is readable at 0xC0 from the next cycle, and sets pending bit 3.
- R10: A write to 0x84 clears each pending bit whose bus_wdata bit is 1. If a bit is set and cleared in the same cycle, the set wins.
- R11: Offset 0x80 holds a 4-bit enable mask and 0x88 reads pending AND enable. irq is high exactly when that AND is non-zero, and it changes in the same cycle as the pending and enable registers.
- R12: After reset, the enable, pending, sync ID and soft reset registers read 0, the queues are empty, the rooms read at full depth, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | 16 | Head command word |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Head transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive queue can accept |
| rx_data | input | 8 | Received byte |
| sync_valid | input | 1 | Sync event from the engine |
| sync_id | input | 8 | ID carried by the sync event |
| eng_rst | output | 1 | Soft reset hold for the engine |
| irq | output | 1 | Interrupt request |

## Verification
Read data and rvalid appear one cycle after the strobe. Queue contents, the stream outputs, eng_rst and the enable and sync ID registers change one cycle after the write or handshake that causes them. Pending bits and irq follow a level condition one cycle after the queue counts that drive it change, so the bit lags the push or pop by two cycles. The bench holds a behavioural model built on queues and steps it once per clock, before the edge, from the same inputs the design sees. It compares every output just after the edge, so each result is checked in exactly the cycle it is due.

// File: rtl/spife_pkg.sv
package spife_pkg;
  localparam logic [7:0] A_VER   = 8'h00;
  localparam logic [7:0] A_SRST  = 8'h40;
  localparam logic [7:0] A_IEN   = 8'h80;
  localparam logic [7:0] A_IPEND = 8'h84;
  localparam logic [7:0] A_ISRC  = 8'h88;
  localparam logic [7:0] A_SYNC  = 8'hC0;
  localparam logic [7:0] A_CROOM = 8'hD0;
  localparam logic [7:0] A_TROOM = 8'hD4;
  localparam logic [7:0] A_RLVL  = 8'hD8;
  localparam logic [7:0] A_CPUSH = 8'hE0;
  localparam logic [7:0] A_TPUSH = 8'hE4;
  localparam logic [7:0] A_RPOP  = 8'hE8;
  localparam logic [7:0] A_RPEEK = 8'hEC;

  localparam int unsigned IRQ_N = 4;
  localparam int unsigned IB_CMD  = 0;
  localparam int unsigned IB_TX   = 1;
  localparam int unsigned IB_RX   = 2;
  localparam int unsigned IB_SYNC = 3;

  localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/spife_fifo.sv
module spife_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spife_irq.sv
module spife_irq #(
  parameter int unsigned N            = 4,
  parameter logic [N-1:0] EDGE_MASK   = '1,
  parameter logic [N-1:0] PREV_INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cond,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] set_v, pend_d, en_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= PREV_INIT[i];
        else     prev_q <= cond[i];
      end
      assign set_v[i] = cond[i] && !prev_q;
    end else begin : g_pulse
      assign set_v[i] = cond[i];
    end
  end

  assign pend_d = (pend & ~(clr_we ? clr_mask : '0)) | set_v;
  assign en_d   = en_we ? en_wdata : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      en   <= en_d;
      irq  <= |(pend_d & en_d);
    end
  end
endmodule

// File: rtl/spi_front_regs.sv
module spi_front_regs
  import spife_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned TX_DEPTH  = 16,
  parameter int unsigned RX_DEPTH  = 16,
  parameter int unsigned CMD_AE    = 2,
  parameter int unsigned TX_AE     = 2,
  parameter int unsigned RX_AF     = 12,
  parameter logic [7:0]  VER_MINOR = 8'd2,
  parameter logic [7:0]  VER_PATCH = 8'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [15:0]       cmd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              sync_valid,
  input  logic [7:0]        sync_id,
  output logic              eng_rst,
  output logic              irq
);
  localparam int unsigned CLW = $clog2(CMD_DEPTH + 1);
  localparam int unsigned TLW = $clog2(TX_DEPTH + 1);
  localparam int unsigned RLW = $clog2(RX_DEPTH + 1);

  logic            soft_rst_q;
  logic [7:0]      sync_id_q;
  logic [CLW-1:0]  cmd_lvl;
  logic [TLW-1:0]  tx_lvl;
  logic [RLW-1:0]  rx_lvl;
  logic            cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
  logic [15:0]     cmd_head;
  logic [7:0]      tx_head, rx_head, rx_front;
  logic [IRQ_N-1:0] pend_q, en_q, irq_cond;
  logic [31:0]     rd_val;
  logic            unused_hi;

  assign unused_hi = ^bus_wdata[31:16];

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  // Queues
  spife_fifo #(.W(16), .DEPTH(CMD_DEPTH)) cmd_q_i (
    .clk(clk), .rst(rst), .clr(soft_rst_q),
    .push(bus_wr && at(bus_addr, A_CPUSH)), .din(bus_wdata[15:0]),
    .pop(cmd_ready && cmd_valid), .head(cmd_head),
    .level(cmd_lvl), .full(cmd_full), .empty(cmd_empty)
  );

  spife_fifo #(.W(8), .DEPTH(TX_DEPTH)) tx_q_i (
    .clk(clk), .rst(rst), .clr(soft_rst_q),
    .push(bus_wr && at(bus_addr, A_TPUSH)), .din(bus_wdata[7:0]),
    .pop(tx_ready && tx_valid), .head(tx_head),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  spife_fifo #(.W(8), .DEPTH(RX_DEPTH)) rx_q_i (
    .clk(clk), .rst(rst), .clr(soft_rst_q),
    .push(rx_valid && rx_ready), .din(rx_data),
    .pop(bus_rd && at(bus_addr, A_RPOP)), .head(rx_head),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid = !cmd_empty && !soft_rst_q;
  assign cmd_data  = cmd_head;
  assign tx_valid  = !tx_empty && !soft_rst_q;
  assign tx_data   = tx_head;
  assign rx_ready  = !rx_full && !soft_rst_q;
  assign rx_front  = rx_empty ? 8'h00 : rx_head;
  assign eng_rst   = soft_rst_q;

  // Interrupt unit
  assign irq_cond[IB_CMD]  = cmd_lvl <= CLW'(CMD_AE);
  assign irq_cond[IB_TX]   = tx_lvl  <= TLW'(TX_AE);
  assign irq_cond[IB_RX]   = rx_lvl  >= RLW'(RX_AF);
  assign irq_cond[IB_SYNC] = sync_valid;

  spife_irq #(
    .N(IRQ_N), .EDGE_MASK(4'b0111), .PREV_INIT(4'b0011)
  ) irq_i (
    .clk(clk), .rst(rst), .cond(irq_cond),
    .clr_we(bus_wr && at(bus_addr, A_IPEND)), .clr_mask(bus_wdata[IRQ_N-1:0]),
    .en_we(bus_wr && at(bus_addr, A_IEN)), .en_wdata(bus_wdata[IRQ_N-1:0]),
    .pend(pend_q), .en(en_q), .irq(irq)
  );

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst_q <= 1'b0;
      sync_id_q  <= '0;
    end else begin
      if (bus_wr && at(bus_addr, A_SRST)) soft_rst_q <= bus_wdata[0];
      if (sync_valid) sync_id_q <= sync_id;
    end
  end

  // Read path
  always_comb begin
    rd_val = '0;
    if      (at(bus_addr, A_VER))   rd_val = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
    else if (at(bus_addr, A_SRST))  rd_val = {31'b0, soft_rst_q};
    else if (at(bus_addr, A_IEN))   rd_val = 32'(en_q);
    else if (at(bus_addr, A_IPEND)) rd_val = 32'(pend_q);
    else if (at(bus_addr, A_ISRC))  rd_val = 32'(pend_q & en_q);
    else if (at(bus_addr, A_SYNC))  rd_val = 32'(sync_id_q);
    else if (at(bus_addr, A_CROOM)) rd_val = 32'(CMD_DEPTH) - 32'(cmd_lvl);
    else if (at(bus_addr, A_TROOM)) rd_val = 32'(TX_DEPTH) - 32'(tx_lvl);
    else if (at(bus_addr, A_RLVL))  rd_val = 32'(rx_lvl);
    else if (at(bus_addr, A_RPOP) || at(bus_addr, A_RPEEK)) rd_val = 32'(rx_front);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/spife_chk.sv
module spife_chk #(
  parameter int unsigned CMD_DEPTH = 16,
  parameter int unsigned RX_DEPTH  = 16,
  parameter int unsigned CLW       = 5,
  parameter int unsigned RLW       = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           bus_rd,
  input logic           bus_rvalid,
  input logic           eng_rst,
  input logic           cmd_valid,
  input logic           tx_valid,
  input logic           rx_ready,
  input logic           sync_valid,
  input logic           irq,
  input logic [3:0]     pend,
  input logic [3:0]     en,
  input logic [CLW-1:0] cmd_lvl,
  input logic [RLW-1:0] rx_lvl
);
  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R2
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> !bus_rvalid);
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_lvl <= CLW'(CMD_DEPTH)) && (rx_lvl <= RLW'(RX_DEPTH)));
  // R5
  rx_full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_lvl == RLW'(RX_DEPTH)) |-> !rx_ready);
  // R7
  hold_stream_chk: assert property (@(posedge clk) disable iff (rst)
    eng_rst |-> (!cmd_valid && !tx_valid && !rx_ready));
  // R9
  sync_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    sync_valid |=> pend[3]);
  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq == ((pend & en) != 4'b0));
endmodule

bind spi_front_regs spife_chk #(
  .CMD_DEPTH(CMD_DEPTH), .RX_DEPTH(RX_DEPTH), .CLW(CLW), .RLW(RLW)
) chk_i (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rvalid(bus_rvalid),
  .eng_rst(eng_rst), .cmd_valid(cmd_valid), .tx_valid(tx_valid),
  .rx_ready(rx_ready), .sync_valid(sync_valid), .irq(irq),
  .pend(pend_q), .en(en_q), .cmd_lvl(cmd_lvl), .rx_lvl(rx_lvl)
);

// File: tb/spi_front_regs_tb_top.sv
module spi_front_regs_tb_top;
  localparam int CD = 16, TD = 16, RD = 16;
  localparam int CAE = 2, TAE = 2, RAF = 12;
  localparam logic [7:0] MINOR = 8'd2, PATCH = 8'd7;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid, cmd_valid, tx_valid, rx_ready, eng_rst, irq;
  logic cmd_ready = 0, tx_ready = 0, rx_valid = 0, sync_valid = 0;
  logic [15:0] cmd_data;
  logic [7:0] tx_data, rx_data = 0, sync_id = 0;

  always #2 clk = ~clk;

  spi_front_regs dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_valid(sync_valid), .sync_id(sync_id), .eng_rst(eng_rst), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  string phase = "init";

  // reference model state
  logic [15:0] mcmd[$];
  logic [7:0]  mtx[$], mrx[$];
  logic [3:0]  m_pend, m_en, m_prev;
  logic [7:0]  m_sid;
  logic        m_srst, m_rvalid, m_irq;
  logic [31:0] m_rdata;
  string       rtag = "";

  task automatic model_step();
    logic [31:0] rv;
    logic [3:0] cnd, setv, clr;
    bit cpop, cpush, tpop, tpush, rpush, rpop;
    if (rst) begin
      mcmd.delete(); mtx.delete(); mrx.delete();
      m_pend = 0; m_en = 0; m_prev = 4'b0011; m_sid = 0; m_srst = 0;
      m_rdata = 0; m_rvalid = 0; m_irq = 0;
      return;
    end
    rv = 0;
    if (bus_rd) begin
      case (bus_addr)
        8'h00: begin rv = {8'h00, 8'h01, MINOR, PATCH}; rtag = "R1 version"; end
        8'h40: begin rv = {31'b0, m_srst}; rtag = "R7 reset reg"; end
        8'h80: begin rv = {28'b0, m_en}; rtag = "R11 enable"; end
        8'h84: begin rv = {28'b0, m_pend}; rtag = "R8 R10 pending"; end
        8'h88: begin rv = {28'b0, m_pend & m_en}; rtag = "R11 source"; end
        8'hC0: begin rv = {24'b0, m_sid}; rtag = "R9 sync id"; end
        8'hD0: begin rv = CD - mcmd.size(); rtag = "R3 cmd room"; end
        8'hD4: begin rv = TD - mtx.size(); rtag = "R4 tx room"; end
        8'hD8: begin rv = mrx.size(); rtag = "R5 rx level"; end
        8'hE8, 8'hEC: begin
          rv = (mrx.size() > 0) ? {24'b0, mrx[0]} : 32'd0;
          rtag = (mrx.size() > 0) ? "R5 rx data" : "R6 empty pop";
        end
        default: begin rv = 0; rtag = "R1 unmapped"; end
      endcase
    end
    m_rdata = rv;
    m_rvalid = bus_rd;
    cnd[0] = mcmd.size() <= CAE;
    cnd[1] = mtx.size() <= TAE;
    cnd[2] = mrx.size() >= RAF;
    cnd[3] = sync_valid;
    setv = {sync_valid, cnd[2:0] & ~m_prev[2:0]};
    m_prev = {1'b0, cnd[2:0]};
    clr = (bus_wr && bus_addr == 8'h84) ? bus_wdata[3:0] : 4'b0;
    m_pend = (m_pend & ~clr) | setv;
    if (bus_wr && bus_addr == 8'h80) m_en = bus_wdata[3:0];
    if (sync_valid) m_sid = sync_id;
    if (m_srst) begin
      mcmd.delete(); mtx.delete(); mrx.delete();
    end else begin
      cpop  = cmd_ready && mcmd.size() > 0;
      cpush = bus_wr && bus_addr == 8'hE0 && mcmd.size() < CD;
      tpop  = tx_ready && mtx.size() > 0;
      tpush = bus_wr && bus_addr == 8'hE4 && mtx.size() < TD;
      rpush = rx_valid && mrx.size() < RD;
      rpop  = bus_rd && bus_addr == 8'hE8 && mrx.size() > 0;
      if (cpop) void'(mcmd.pop_front());
      if (cpush) mcmd.push_back(bus_wdata[15:0]);
      if (tpop) void'(mtx.pop_front());
      if (tpush) mtx.push_back(bus_wdata[7:0]);
      if (rpop) void'(mrx.pop_front());
      if (rpush) mrx.push_back(rx_data);
    end
    if (bus_wr && bus_addr == 8'h40) m_srst = bus_wdata[0];
    m_irq = |(m_pend & m_en);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%h expected=%h", tag, phase, act, exp);
    end
  endtask

  task automatic check_outputs();
    bit mcv, mtv, mrr;
    mcv = !m_srst && mcmd.size() > 0;
    mtv = !m_srst && mtx.size() > 0;
    mrr = !m_srst && mrx.size() < RD;
    chk("R2 rvalid", {31'b0, bus_rvalid}, {31'b0, m_rvalid});
    if (m_rvalid) chk(rtag, bus_rdata, m_rdata);
    chk("R11 irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R7 eng_rst", {31'b0, eng_rst}, {31'b0, m_srst});
    chk("R3 cmd_valid", {31'b0, cmd_valid}, {31'b0, mcv});
    if (mcv) chk("R3 cmd_data", {16'b0, cmd_data}, {16'b0, mcmd[0]});
    chk("R4 tx_valid", {31'b0, tx_valid}, {31'b0, mtv});
    if (mtv) chk("R4 tx_data", {24'b0, tx_data}, {24'b0, mtx[0]});
    chk("R5 rx_ready", {31'b0, rx_ready}, {31'b0, mrr});
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    check_outputs();
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    bus_rd = 1; bus_addr = a;
    tick();
    bus_rd = 0;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    phase = "reset";
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();

    phase = "R12 reset state";
    bus_read(8'hD0); bus_read(8'hD4); bus_read(8'hD8);
    bus_read(8'h84); bus_read(8'h80); bus_read(8'hC0); bus_read(8'h40);

    phase = "R1 identity";
    bus_read(8'h00); bus_read(8'h10); bus_read(8'hFC);

    phase = "R3 command queue";
    for (int i = 0; i < 5; i++) bus_write(8'hE0, 32'hA500 + i);
    bus_read(8'hD0);
    cmd_ready = 1;
    repeat (6) tick();
    cmd_ready = 0;
    tick();
    phase = "R8 cmd almost empty";
    bus_read(8'h84);

    phase = "R4 R6 transmit overfill";
    for (int i = 0; i < TD + 3; i++) bus_write(8'hE4, 32'h30 + i);
    bus_read(8'hD4);
    tx_ready = 1;
    repeat (TD + 2) tick();
    tx_ready = 0;
    bus_read(8'hD4);
    bus_read(8'h84);

    phase = "R5 R6 receive";
    for (int i = 0; i < RD + 2; i++) begin
      rx_valid = 1; rx_data = 8'hC0 ^ 8'(i * 7);
      tick();
    end
    rx_valid = 0;
    tick();
    bus_read(8'hD8);
    bus_read(8'h84);
    bus_read(8'hEC); bus_read(8'hEC);
    for (int i = 0; i < RD + 2; i++) bus_read(8'hE8);
    bus_read(8'hD8);
    bus_read(8'hEC);

    phase = "R11 enable and source";
    bus_write(8'h80, 32'hF);
    bus_read(8'h80); bus_read(8'h88);
    bus_write(8'h80, 32'h4);
    bus_read(8'h88);

    phase = "R10 clear";
    bus_write(8'h84, 32'h4);
    bus_read(8'h84);
    bus_write(8'h84, 32'hFF);
    bus_read(8'h84); bus_read(8'h88);

    phase = "R9 sync";
    bus_write(8'h80, 32'h8);
    sync_valid = 1; sync_id = 8'h5A;
    tick();
    sync_valid = 0;
    tick();
    bus_read(8'hC0); bus_read(8'h84);
    bus_write(8'h84, 32'h8);
    tick();

    phase = "R10 set wins";
    sync_valid = 1; sync_id = 8'h33;
    bus_write(8'h84, 32'h8);
    sync_valid = 0;
    bus_read(8'h84); bus_read(8'hC0);

    phase = "R7 soft reset";
    for (int i = 0; i < 4; i++) bus_write(8'hE0, 32'h1200 + i);
    bus_write(8'hE4, 32'h99);
    bus_write(8'h40, 32'h1);
    tick();
    bus_read(8'h40);
    bus_write(8'hE0, 32'hBEEF);
    rx_valid = 1; rx_data = 8'h77;
    tick();
    rx_valid = 0;
    bus_read(8'hD0); bus_read(8'hD4); bus_read(8'hD8);
    bus_write(8'h40, 32'h0);
    tick();
    bus_write(8'hE0, 32'h4321);
    bus_read(8'hD0);
    cmd_ready = 1;
    repeat (3) tick();
    cmd_ready = 0;
    bus_read(8'h84);
    repeat (3) tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule